// File: doc/BRIEF.md
# Channel Interrupt Vector Generator

This block gathers interrupt requests from a bank of timer channels and raises one shared request toward the system at a programmable priority level. Each channel keeps a sticky pending flag. A one-cycle request pulse sets the flag. The flag is cleared when that channel's interrupt is serviced or when software writes a clear bit. A channel takes part in a request only while its enable bit is set. Among the pending and enabled channels, the lowest-numbered one is serviced first.

The interrupt controller answers a request with an acknowledge cycle. That cycle carries the level being acknowledged and the highest arbitration ID among the other modules that request at the same level. The block claims the cycle only when three things hold: the acknowledged level equals its own, its arbitration ID is non-zero, and its ID is strictly higher than the competing one. It then returns an 8-bit vector. The upper nibble is the programmed base and the lower nibble is the serviced channel number. A level of zero keeps the block silent. A level of seven flags the request as nonmaskable.

A three-state machine drives the behaviour:
- `ST_IDLE`: no request is presented.
- `ST_REQ`: the level is presented.
- `ST_VEC`: the vector is on the bus for one cycle.

The transitions are:
- idle-to-request: an eligible channel exists.
- request-to-idle: the eligibility is lost.
- request-to-vector: an acknowledge is won.
- vector-to-request: more channels are still eligible.
- vector-to-idle: no channel is left.

Top module: `irq_vec_gen`

## Requirements
- R1: When at least one channel is both pending and enabled and `cfg_level` is non-zero, `irq_level` equals `cfg_level` from the second clock edge after the request pulse is sampled. Otherwise `irq_level` is 0.
- R2: With `cfg_level` = 0, `irq_level` stays 0 and no acknowledge is ever claimed, even with channels pending.
- R3: `irq_nmi` is 1 exactly when a request is presented with `cfg_level` = 7.
- R4: A claimed acknowledge yields `vec_out[7:4]` = `cfg_base` and `vec_out[3:0]` = the serviced channel number.
- R5: The serviced channel is the lowest-numbered channel that is both pending and enabled at the acknowledge edge.
- R6: A pending flag is sticky. Disabling the channel hides it without clearing it, and servicing clears only the serviced channel.
- R7: `sw_clr[i]` clears pending flag i. A request pulse on the same channel in the same cycle wins, so the flag stays set.
- R8: An acknowledge is claimed only if `ack_level` equals `cfg_level` and `cfg_arb_id` is strictly greater than `ack_arb_id`. When it is not claimed, the request stays asserted and no vector appears.
- R9: With `cfg_arb_id` = 0, no acknowledge is ever claimed.
- R10: After reset, every pending flag is clear and all outputs are 0.
- R11: `arb_win` is 1 combinationally in the acknowledge cycle that is claimed. In the next cycle `vec_valid` is 1 for exactly one cycle and `irq_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pulse | input | 16 | Per-channel request pulses |
| chan_en | input | 16 | Per-channel interrupt enables |
| sw_clr | input | 16 | Per-channel software clear of the pending flag |
| cfg_level | input | 3 | Shared request level (0 off, 7 nonmaskable) |
| cfg_base | input | 4 | Upper nibble of every channel vector |
| cfg_arb_id | input | 4 | This module's arbitration ID |
| ack_valid | input | 1 | An acknowledge cycle is in progress |
| ack_level | input | 3 | Level being acknowledged |
| ack_arb_id | input | 4 | Highest competing arbitration ID |
| irq_level | output | 3 | Presented request level |
| irq_nmi | output | 1 | Presented request is nonmaskable |
| arb_win | output | 1 | This block claims the current acknowledge |
| vec_valid | output | 1 | `vec_out` holds a vector |
| vec_out | output | 8 | Interrupt vector |

## Verification
The bench targets these corner cases and the fault each one would expose:
- Two channels pending at once: a wrong priority encoder returns the higher channel number.
- An acknowledge at the wrong level, against an equal or higher competing ID, or with ID 0: a design with a loose comparison claims the cycle and puts a vector on a bus it does not own.
- A channel disabled while pending: a design that loses the flag never services it after re-enabling.
- A pulse that coincides with a software clear: a design with the wrong set/clear priority drops the new request.
- Level 0 and level 7: these show a design that still requests while switched off or that fails to flag the nonmaskable case.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_VEC  = 2'd2
    } irq_st_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] pend_o
);
    // one flop per channel; a set wins over a clear in the same cycle
    for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_o[g] <= 1'b0;
            else if (set_i[g])
                pend_o[g] <= 1'b1;
            else if (clr_i[g])
                pend_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_CH = 16,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] elig_i,
    output logic              found_o,
    output logic [CH_W-1:0]   idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // scan downward so the lowest eligible index is written last
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                found_o = 1'b1;
                idx_o   = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_arb_judge.sv
module irq_arb_judge #(
    parameter int LVL_W = 3,
    parameter int ID_W  = 4
) (
    input  logic             ack_valid_i,
    input  logic [LVL_W-1:0] ack_level_i,
    input  logic [ID_W-1:0]  ack_id_i,
    input  logic [LVL_W-1:0] own_level_i,
    input  logic [ID_W-1:0]  own_id_i,
    output logic             hit_o
);
    logic lvl_match;
    logic id_live;
    logic id_beats;

    always_comb begin
        lvl_match = (ack_level_i == own_level_i) && (own_level_i != '0);
        id_live   = (own_id_i != '0);
        id_beats  = (own_id_i > ack_id_i);
        hit_o     = ack_valid_i && lvl_match && id_live && id_beats;
    end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
    parameter int NUM_CH = 16,
    parameter int LVL_W  = 3,
    parameter int ID_W   = 4,
    parameter int BASE_W = 4,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int VEC_W = BASE_W + CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_pulse,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [NUM_CH-1:0] sw_clr,
    input  logic [LVL_W-1:0]  cfg_level,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [ID_W-1:0]   cfg_arb_id,
    input  logic              ack_valid,
    input  logic [LVL_W-1:0]  ack_level,
    input  logic [ID_W-1:0]   ack_arb_id,
    output logic [LVL_W-1:0]  irq_level,
    output logic              irq_nmi,
    output logic              arb_win,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_out
);
    import irq_vec_pkg::*;

    localparam logic [LVL_W-1:0] LVL_NMI = {LVL_W{1'b1}};

    irq_st_e           state_q, state_d;
    logic [CH_W-1:0]   serv_q;
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] svc_mask;
    logic [NUM_CH-1:0] clr_all;
    logic              pick_found;
    logic [CH_W-1:0]   pick_idx;
    logic              ack_hit;
    logic              take;
    logic              any_elig;

    assign elig     = pend & chan_en;
    assign any_elig = pick_found && (cfg_level != '0);
    assign take     = (state_q == ST_REQ) && ack_hit;

    // one-hot clear of the channel being serviced
    for (genvar g = 0; g < NUM_CH; g++) begin : g_svc
        assign svc_mask[g] = take && (pick_idx == CH_W'(g));
    end
    assign clr_all = sw_clr | svc_mask;

    irq_pend_bank #(.NUM_CH(NUM_CH)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_pulse),
        .clr_i  (clr_all),
        .pend_o (pend)
    );

    irq_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
        .elig_i  (elig),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    irq_arb_judge #(.LVL_W(LVL_W), .ID_W(ID_W)) u_judge (
        .ack_valid_i (ack_valid),
        .ack_level_i (ack_level),
        .ack_id_i    (ack_arb_id),
        .own_level_i (cfg_level),
        .own_id_i    (cfg_arb_id),
        .hit_o       (ack_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = any_elig ? ST_REQ : ST_IDLE;
            ST_REQ:  begin
                if (take)          state_d = ST_VEC;
                else if (any_elig) state_d = ST_REQ;
                else               state_d = ST_IDLE;
            end
            ST_VEC:  state_d = any_elig ? ST_REQ : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and serviced-channel latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            serv_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take)
                serv_q <= pick_idx;
        end
    end

    // outputs decoded from state
    always_comb begin
        irq_level = '0;
        irq_nmi   = 1'b0;
        arb_win   = 1'b0;
        vec_valid = 1'b0;
        vec_out   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  begin
                irq_level = cfg_level;
                irq_nmi   = (cfg_level == LVL_NMI);
                arb_win   = ack_hit;
            end
            ST_VEC:  begin
                vec_valid = 1'b1;
                vec_out   = {cfg_base, serv_q};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
    parameter int LVL_W  = 3,
    parameter int ID_W   = 4,
    parameter int VEC_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] cfg_level,
    input logic [ID_W-1:0]  cfg_arb_id,
    input logic             ack_valid,
    input logic [LVL_W-1:0] ack_level,
    input logic [ID_W-1:0]  ack_arb_id,
    input logic [LVL_W-1:0] irq_level,
    input logic             irq_nmi,
    input logic             arb_win,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_out
);
    p_lvl0_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(cfg_level) != '0);

    p_nmi_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nmi |-> irq_level == {LVL_W{1'b1}});

    p_ack_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_valid && ack_level == cfg_level && cfg_arb_id > ack_arb_id));

    p_id_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(cfg_arb_id) != '0);

    p_win_then_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
        arb_win |=> vec_valid);

    p_vec_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    p_vec_drops_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (irq_level == '0 && !arb_win));
endmodule

bind irq_vec_gen irq_vec_chk #(.LVL_W(LVL_W), .ID_W(ID_W), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_level  (cfg_level),
    .cfg_arb_id (cfg_arb_id),
    .ack_valid  (ack_valid),
    .ack_level  (ack_level),
    .ack_arb_id (ack_arb_id),
    .irq_level  (irq_level),
    .irq_nmi    (irq_nmi),
    .arb_win    (arb_win),
    .vec_valid  (vec_valid),
    .vec_out    (vec_out)
);

// File: tb/test_irq_vec_gen.sv
module test_irq_vec_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_pulse = '0;
    logic [15:0] chan_en = '0;
    logic [15:0] sw_clr = '0;
    logic [2:0]  cfg_level = '0;
    logic [3:0]  cfg_base = '0;
    logic [3:0]  cfg_arb_id = '0;
    logic        ack_valid = 1'b0;
    logic [2:0]  ack_level = '0;
    logic [3:0]  ack_arb_id = '0;
    logic [2:0]  irq_level;
    logic        irq_nmi;
    logic        arb_win;
    logic        vec_valid;
    logic [7:0]  vec_out;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_pend = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vec_gen i_irq_vec_gen (
        .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .chan_en(chan_en),
        .sw_clr(sw_clr), .cfg_level(cfg_level), .cfg_base(cfg_base),
        .cfg_arb_id(cfg_arb_id), .ack_valid(ack_valid), .ack_level(ack_level),
        .ack_arb_id(ack_arb_id), .irq_level(irq_level), .irq_nmi(irq_nmi),
        .arb_win(arb_win), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    function automatic logic exp_req();
        return (cfg_level != 3'd0) && ((exp_pend & chan_en) != 16'd0);
    endfunction

    function automatic logic [3:0] exp_low();
        logic [15:0] e = exp_pend & chan_en;
        for (int i = 0; i < 16; i++) if (e[i]) return 4'(i);
        return 4'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // drives for one cycle starting just after a falling edge
    task automatic step(input logic [15:0] p, input logic [15:0] c);
        req_pulse = p;
        sw_clr    = c;
        @(posedge clk);
        exp_pend = (exp_pend & ~c) | p;
        @(negedge clk);
        req_pulse = '0;
        sw_clr    = '0;
    endtask

    task automatic chk_level(input string tag);
        #1;
        chk({tag, " level"}, 32'(irq_level), exp_req() ? 32'(cfg_level) : 32'd0);
        chk({tag, " nmi"}, 32'(irq_nmi), 32'(exp_req() && cfg_level == 3'd7));
    endtask

    task automatic do_ack(input string tag, input logic [2:0] lvl, input logic [3:0] cid);
        logic       hit;
        logic [3:0] ch;
        ack_valid  = 1'b1;
        ack_level  = lvl;
        ack_arb_id = cid;
        #1;
        hit = exp_req() && lvl == cfg_level && cfg_arb_id != 4'd0 && cfg_arb_id > cid;
        ch  = exp_low();
        chk({tag, " arb_win"}, 32'(arb_win), 32'(hit));
        @(posedge clk);
        if (hit) exp_pend[ch] = 1'b0;
        @(negedge clk);
        ack_valid = 1'b0;
        #1;
        chk({tag, " vec_valid"}, 32'(vec_valid), 32'(hit));
        if (hit) begin
            chk({tag, " vec_out"}, 32'(vec_out), 32'({cfg_base, ch}));
            chk({tag, " level in vector cycle"}, 32'(irq_level), 32'd0);
        end
        step('0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset level", 32'(irq_level), 0);
        chk("R10 reset vec", 32'({vec_valid, arb_win, irq_nmi, vec_out}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_level = 3'd3; cfg_base = 4'hA; cfg_arb_id = 4'd5; chan_en = 16'hFFFF;
        step('0, '0);
        chk_level("R10 empty after reset");

        // R1 two-edge latency, R5 lowest first, R4 vector format
        step(16'h0220, '0);
        #1; chk("R1 not yet presented", 32'(irq_level), 0);
        step('0, '0);
        chk_level("R1 presented");
        do_ack("R4 R5 first service", 3'd3, 4'd4);
        chk_level("R6 remaining channel still requests");

        // R8 losing acknowledges
        do_ack("R8 wrong level", 3'd2, 4'd0);
        do_ack("R8 higher competitor", 3'd3, 4'd6);
        do_ack("R8 equal competitor", 3'd3, 4'd5);
        chk_level("R8 request held");

        // R6 disabled channel stays pending
        chan_en = 16'h0000; step('0, '0);
        chk_level("R6 hidden when disabled");
        chan_en = 16'hFFFF; step('0, '0);
        chk_level("R6 back after enable");
        do_ack("R6 serviced after enable", 3'd3, 4'd1);
        chk_level("R6 all serviced");

        // R7 software clear and set priority
        step(16'h0004, '0); step('0, 16'h0004); step('0, '0);
        chk_level("R7 cleared by software");
        step(16'h0008, 16'h0008); step('0, '0);
        chk_level("R7 set wins over clear");
        do_ack("R7 survivor serviced", 3'd3, 4'd0);

        // R3 nonmaskable level
        cfg_level = 3'd7; step(16'h8000, '0); step('0, '0);
        chk_level("R3 level seven");
        // R2 level zero silent
        cfg_level = 3'd0; step('0, '0);
        chk_level("R2 level zero");
        do_ack("R2 no claim at level zero", 3'd0, 4'd0);
        // R9 id zero never claims
        cfg_level = 3'd7; cfg_arb_id = 4'd0; step('0, '0);
        do_ack("R9 id zero", 3'd7, 4'd0);
        cfg_arb_id = 4'd9; step('0, '0);
        do_ack("R4 channel fifteen", 3'd7, 4'd3);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [15:0] p  = 16'($urandom) & 16'($urandom);
            logic [15:0] c  = 16'($urandom) & 16'($urandom) & 16'($urandom);
            if ($urandom_range(0, 7) == 0) cfg_level  = 3'($urandom);
            if ($urandom_range(0, 7) == 0) cfg_base   = 4'($urandom);
            if ($urandom_range(0, 7) == 0) cfg_arb_id = 4'($urandom);
            if ($urandom_range(0, 3) == 0) chan_en    = 16'($urandom) | 16'($urandom);
            step(p, c);
            step('0, '0);
            chk_level("R1 R6 R7 random level");
            if ($urandom_range(0, 1) == 1)
                do_ack("R5 R8 random ack",
                       ($urandom_range(0, 3) == 0) ? 3'($urandom) : cfg_level,
                       4'($urandom_range(0, 12)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule